// File: doc/BRIEF.md
# Burst Beat Address Generator

This block turns one burst command into the sequence of byte addresses that the burst's beats use. A command carries a start address, a beat count minus one, a transfer size code and a burst type. It is taken through a valid/ready handshake. While a burst is in progress, the block presents the current beat's address together with a flag that marks the final beat. It moves to the next address each time the consumer pulses the beat-accept strobe.

Three burst types are handled. A fixed burst repeats its start address. An incrementing burst steps upward by the transfer size. A wrapping burst stays inside an aligned block whose size is the beat count times the bytes per beat. That last type supports cache-line fills that return the requested word first.

A wrapping command whose length or start alignment breaks the rules is refused: the block raises an error pulse and emits no beats. A command that uses the reserved type code is refused the same way. No data moves through the block.

Top module: `burst_addr_gen`

## Requirements
- R1: Out of reset `cmd_ready` is 1, `beat_valid` is 0, `beat_last` is 0 and `cmd_err` is 0.
- R2: `cmd_ready` is 1 exactly when no burst is in progress. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. If the command is legal, `beat_valid` is 1 in the following cycle and `beat_addr` equals the command's start address.
- R3: While `beat_valid` is 1 and `beat_accept` is 0, `beat_addr` and `beat_last` hold their values. Each edge with `beat_valid` and `beat_accept` both 1 consumes one beat.
- R4: A burst has `cmd_len`+1 beats, and `beat_last` is 1 only on the beat with index `cmd_len` (counting from 0). After that beat is consumed, `beat_valid` is 0 and `cmd_ready` is 1 in the next cycle.
- R5: With `cmd_burst` = 2'b00 (fixed), every beat address equals the start address.
- R6: With `cmd_burst` = 2'b01 (incrementing), the start address may be unaligned. Each later beat address is the previous one with its low `cmd_size` bits cleared, plus 2^`cmd_size`.
- R7: With `cmd_burst` = 2'b10 (wrapping), the address steps by 2^`cmd_size`. The block is (`cmd_len`+1)·2^`cmd_size` bytes and is aligned to that size. When a step would reach the block's lower edge plus the block size, the next address is the lower edge. Example: length code 3, size code 2 and start 0x08 give 0x08, 0x0C, 0x00, 0x04.
- R8: A wrapping command with `cmd_len` other than 1, 3, 7 or 15 is illegal.
- R9: A wrapping command whose start address is not a multiple of 2^`cmd_size` is illegal.
- R10: A command with `cmd_burst` = 2'b11 is illegal.
- R11: An illegal command is still taken. In the next cycle `cmd_err` is 1 for exactly one cycle, `beat_valid` stays 0 and `cmd_ready` stays 1.
- R12: Size codes 0 through 7 (1 to 128 bytes per beat) are all handled by every burst type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_addr | input | AW | Start byte address |
| cmd_len | input | 8 | Beats in burst minus one |
| cmd_size | input | 3 | log2 of bytes per beat |
| cmd_burst | input | 2 | 00 fixed, 01 incrementing, 10 wrapping, 11 reserved |
| cmd_err | output | 1 | One-cycle pulse after an illegal command is taken |
| beat_valid | output | 1 | A beat address is presented |
| beat_addr | output | AW | Byte address of the current beat |
| beat_last | output | 1 | Current beat is the final one |
| beat_accept | input | 1 | Consumer takes the current beat |

## Verification
The address register and the beat counter are the only state that can go wrong unseen. If the address register is wrong, the error appears on `beat_addr` in the first cycle after the beat that stepped wrongly. A bad wrap edge shows up at the first fold, two to sixteen beats into a wrapping burst. If the counter is wrong, `beat_last` moves off the final beat, and the burst either ends early or runs past its length. That is visible no later than beat `cmd_len`+1. A legality mistake appears one cycle after the command is taken: either `cmd_err` pulses, or `beat_valid` rises.

// File: rtl/bag_pkg.sv
package bag_pkg;

  typedef enum logic [1:0] {
    BT_FIXED = 2'b00,
    BT_INCR  = 2'b01,
    BT_WRAP  = 2'b10,
    BT_RSVD  = 2'b11
  } burst_e;

  localparam int unsigned LEN_W  = 8;
  localparam int unsigned SIZE_W = 3;
  // widest wrap block: 16 beats of 128 bytes = 2048 bytes -> 11 offset bits
  localparam int unsigned OFS_W  = 12;

  // low-bit mask of one beat's byte span
  function automatic logic [OFS_W-1:0] beat_mask(input logic [SIZE_W-1:0] size);
    return (OFS_W'(1) << size) - OFS_W'(1);
  endfunction

  // low-bit mask of a wrap block: ((len+1) << size) - 1, len limited to 4 bits
  function automatic logic [OFS_W-1:0] block_mask(input logic [3:0] len_lo,
                                                   input logic [SIZE_W-1:0] size);
    return ((OFS_W'(len_lo) + OFS_W'(1)) << size) - OFS_W'(1);
  endfunction

  function automatic logic wrap_len_legal(input logic [LEN_W-1:0] len);
    return (len == 8'd1) || (len == 8'd3) || (len == 8'd7) || (len == 8'd15);
  endfunction

endpackage

// File: rtl/bag_cmd_check.sv
module bag_cmd_check
  import bag_pkg::*;
(
  input  logic [OFS_W-1:0]  addr_lo,
  input  logic [LEN_W-1:0]  len,
  input  logic [SIZE_W-1:0] size,
  input  logic [1:0]        burst,
  output logic              legal
);

  logic wrap_len_ok;
  logic wrap_align_ok;

  always_comb begin
    wrap_len_ok   = wrap_len_legal(len);
    wrap_align_ok = ((addr_lo & beat_mask(size)) == '0);
    unique case (burst)
      BT_FIXED: legal = 1'b1;
      BT_INCR:  legal = 1'b1;
      BT_WRAP:  legal = wrap_len_ok & wrap_align_ok;
      default:  legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/bag_next_addr.sv
module bag_next_addr
  import bag_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0]     cur_addr,
  input  logic [SIZE_W-1:0] size,
  input  logic [OFS_W-1:0]  wmask,
  input  burst_e            burst,
  output logic [AW-1:0]     nxt_addr
);

  logic [AW-1:0] step;
  logic [AW-1:0] smask;
  logic [AW-1:0] bmask;
  logic [AW-1:0] bumped;

  always_comb begin
    step   = AW'(1) << size;
    smask  = AW'(beat_mask(size));
    bmask  = AW'(wmask);
    bumped = cur_addr + step;
    unique case (burst)
      BT_INCR:  nxt_addr = (cur_addr & ~smask) + step;
      BT_WRAP:  nxt_addr = (cur_addr & ~bmask) | (bumped & bmask);
      default:  nxt_addr = cur_addr;
    endcase
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [AW-1:0]     cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [SIZE_W-1:0] cmd_size,
  input  logic [1:0]        cmd_burst,
  output logic              cmd_err,
  output logic              beat_valid,
  output logic [AW-1:0]     beat_addr,
  output logic              beat_last,
  input  logic              beat_accept
);

  logic              busy_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  len_q;
  logic [SIZE_W-1:0] size_q;
  burst_e            burst_q;
  logic [OFS_W-1:0]  wmask_q;
  logic [AW-1:0]     addr_q;
  logic              err_q;

  // named events
  logic          cmd_fire;
  logic          cmd_legal;
  logic          beat_fire;
  logic          final_beat;
  logic          wrap_fold;
  logic [AW-1:0] nxt_addr;

  bag_cmd_check u_check (
    .addr_lo (cmd_addr[OFS_W-1:0]),
    .len     (cmd_len),
    .size    (cmd_size),
    .burst   (cmd_burst),
    .legal   (cmd_legal)
  );

  bag_next_addr #(.AW(AW)) u_next (
    .cur_addr (addr_q),
    .size     (size_q),
    .wmask    (wmask_q),
    .burst    (burst_q),
    .nxt_addr (nxt_addr)
  );

  assign cmd_ready  = ~busy_q;
  assign cmd_fire   = cmd_valid & cmd_ready;
  assign beat_fire  = busy_q & beat_accept;
  assign final_beat = busy_q & (cnt_q == len_q);
  assign wrap_fold  = beat_fire & ~final_beat & (burst_q == BT_WRAP) & (nxt_addr < addr_q);

  assign beat_valid = busy_q;
  assign beat_addr  = addr_q;
  assign beat_last  = final_beat;
  assign cmd_err    = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      len_q   <= '0;
      size_q  <= '0;
      burst_q <= BT_FIXED;
      wmask_q <= '0;
      addr_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= cmd_fire & ~cmd_legal;
      if (cmd_fire && cmd_legal) begin
        busy_q  <= 1'b1;
        cnt_q   <= '0;
        len_q   <= cmd_len;
        size_q  <= cmd_size;
        burst_q <= burst_e'(cmd_burst);
        wmask_q <= block_mask(cmd_len[3:0], cmd_size);
        addr_q  <= cmd_addr;
      end else if (beat_fire) begin
        if (final_beat) begin
          busy_q <= 1'b0;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
          addr_q <= nxt_addr;
        end
      end
    end
  end

  // R2
  first_beat_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && cmd_legal |=> beat_valid && (beat_addr == $past(cmd_addr)));

  // R3
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_accept |=> beat_valid && $stable(beat_addr) && $stable(beat_last));

  // R4
  end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_accept && beat_last |=> !beat_valid && cmd_ready);

  // R5
  fixed_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && !beat_last && (burst_q == BT_FIXED) |=> $stable(beat_addr));

  // R7
  wrap_in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && !beat_last && (burst_q == BT_WRAP)
    |=> (beat_addr & ~AW'(wmask_q)) == ($past(beat_addr) & ~AW'(wmask_q)));

  // R7
  wrap_fold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_fold |=> (beat_addr & AW'(wmask_q)) == '0);

  // R11
  illegal_no_beats_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && !cmd_legal |=> cmd_err && !beat_valid && cmd_ready);

  // R11
  err_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> !cmd_err);

endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0]    cmd_len = '0;
  logic [2:0]    cmd_size = '0;
  logic [1:0]    cmd_burst = '0;
  logic          cmd_err;
  logic          beat_valid;
  logic [AW-1:0] beat_addr;
  logic          beat_last;
  logic          beat_accept = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_addr_gen #(.AW(AW)) dut (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_addr, .cmd_len, .cmd_size,
    .cmd_burst, .cmd_err, .beat_valid, .beat_addr, .beat_last, .beat_accept
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic bit ref_legal(input longint a, input int len, input int size, input int bt);
    if (bt == 3) return 0;
    if (bt != 2) return 1;
    if (!(len == 1 || len == 3 || len == 7 || len == 15)) return 0;
    return (a % (longint'(1) << size)) == 0;
  endfunction

  // address of beat n, from the block-offset formulation
  function automatic longint ref_addr(input longint a, input int len, input int size,
                                      input int bt, input int n);
    longint step, blk, low, base;
    step = longint'(1) << size;
    if (bt == 0 || n == 0) return a;
    if (bt == 1) begin
      base = a - (a % step);
      return (base + n * step) & 64'hFFFF_FFFF;
    end
    blk = (len + 1) * step;
    low = a - (a % blk);
    return low + ((a + n * step - low) % blk);
  endfunction

  task automatic run_burst(input longint a, input int len, input int size, input int bt,
                           input int stall_pct);
    bit legal;
    legal = ref_legal(a, len, size, bt);
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R2 ready when idle", cmd_ready, 1);
    cmd_valid = 1'b1;
    cmd_addr  = a[AW-1:0];
    cmd_len   = len[7:0];
    cmd_size  = size[2:0];
    cmd_burst = bt[1:0];
    @(negedge clk);
    cmd_valid = 1'b0;
    if (!legal) begin
      if (bt == 3)
        chk(cmd_err == 1'b1, "R10 reserved type flagged", cmd_err, 1);
      else if (!(len == 1 || len == 3 || len == 7 || len == 15))
        chk(cmd_err == 1'b1, "R8 wrap length flagged", cmd_err, 1);
      else
        chk(cmd_err == 1'b1, "R9 wrap alignment flagged", cmd_err, 1);
      chk(beat_valid == 1'b0, "R11 no beats for illegal", beat_valid, 0);
      chk(cmd_ready == 1'b1, "R11 ready stays high", cmd_ready, 1);
      @(negedge clk);
      chk(cmd_err == 1'b0, "R11 error one cycle", cmd_err, 0);
      return;
    end
    chk(cmd_err == 1'b0, "R11 no error on legal", cmd_err, 0);
    chk(cmd_ready == 1'b0, "R2 busy during burst", cmd_ready, 0);
    for (int n = 0; n <= len; n++) begin
      longint exp;
      exp = ref_addr(a, len, size, bt, n);
      chk(beat_valid == 1'b1, "R3 beat valid", beat_valid, 1);
      if (bt == 0) chk(beat_addr == exp[AW-1:0], "R5 fixed addr", beat_addr, exp);
      else if (bt == 1) chk(beat_addr == exp[AW-1:0], "R6 incr addr", beat_addr, exp);
      else chk(beat_addr == exp[AW-1:0], "R7 wrap addr", beat_addr, exp);
      chk(beat_last == (n == len), "R4 last flag", beat_last, (n == len));
      if ($urandom_range(99) < stall_pct) begin
        @(negedge clk);
        chk(beat_addr == exp[AW-1:0] && beat_valid, "R3 hold on stall", beat_addr, exp);
      end
      beat_accept = 1'b1;
      @(negedge clk);
      beat_accept = 1'b0;
    end
    chk(beat_valid == 1'b0, "R4 burst ends", beat_valid, 0);
    chk(cmd_ready == 1'b1, "R4 ready after last", cmd_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmd_ready == 1'b1, "R1 ready in reset", cmd_ready, 1);
    chk(beat_valid == 1'b0, "R1 valid low", beat_valid, 0);
    chk(beat_last == 1'b0, "R1 last low", beat_last, 0);
    chk(cmd_err == 1'b0, "R1 err low", cmd_err, 0);
    rst_n = 1'b1;

    // R7 worked example
    run_burst(64'h08, 3, 2, 2, 0);
    run_burst(64'h8000_003C, 15, 2, 2, 30);   // R7 fold on second beat
    run_burst(64'h1000_0780, 15, 7, 2, 0);    // R12 widest block
    run_burst(64'h0000_0001, 1, 0, 2, 0);     // R12 byte wrap
    run_burst(64'hFFFF_FFFD, 5, 1, 1, 20);    // R6 unaligned, address rollover
    run_burst(64'h0000_0103, 0, 3, 1, 0);     // R4 single beat
    run_burst(64'h1234_5678, 7, 5, 0, 40);    // R5 fixed
    run_burst(64'h40, 2, 2, 2, 0);            // R8 len 3 beats
    run_burst(64'h44, 3, 3, 2, 0);            // R9 unaligned wrap
    run_burst(64'h40, 3, 2, 3, 0);            // R10 reserved
    run_burst(64'h0000_2000, 255, 0, 1, 0);   // R4 longest burst

    for (int i = 0; i < 400; i++) begin
      int bt, len, size;
      longint a;
      bt   = $urandom_range(3);
      size = $urandom_range(7);
      a    = longint'($urandom);
      if (bt == 2) begin
        len = (1 << $urandom_range(1, 4)) - 1;
        if ($urandom_range(9) == 0) len = $urandom_range(20);
        if ($urandom_range(9) != 0) a = a - (a % (longint'(1) << size));
      end else begin
        len = $urandom_range(24);
      end
      run_burst(a, len, size, bt, 25);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule